// File: doc/BRIEF.md
# Line-Start Pipeline Sequencer

This block paces a multi-stage image pipeline from a periodic line-start pulse. For every pulse it decides whether one input line is fetched into the pipeline, and whether each output channel writes out a line. The pixel stages and their line buffers are elsewhere. The sequencer only sees their enable flags. Their row and cycle latencies are fixed constants inside the block.

Each output channel stays silent for the first N pulses of a frame. N is that channel's initial-skip count. It absorbs the rows of delay that the enabled stages add, plus an extra term that depends on the channel's kind. Two pacing modes exist:

- **Pulse-locked mode:** every pulse fetches one line, up to the frame height.
- **Free-running mode:** pulses fetch lines only until the pipeline is primed. After that, a local timer issues the fetches, and the pulses govern output writes alone.

The block also reports the smallest horizontal blanking that the enabled stages can tolerate, and it raises a flag when the configured blanking is below that value. A frame-start input restarts all counting.

Top module: `lsq_top`

## Requirements
- R1: After reset, and on the cycle after a sampled `frame_start`, `load_stb` and `out_stb` are low. `frame_start` clears the pulse count, the fetched-line count and the fetch timer, so skip counting restarts.
- R2: `load_stb` (pulse-locked fetch) and `out_stb` are single-cycle strobes. They are registered and rise on the cycle after `line_start` is sampled high.
- R3: With `frame_mode`=0, a pulse fetches a line (`load_stb`) only while the number of lines fetched since `frame_start` is below `frame_height`. Further pulses fetch nothing.
- R4: Number the pulses k=1,2,... from `frame_start`. Pulse k raises `out_stb[c]` if and only if `ch_en[c]`=1 and k is greater than the skip count of channel c.
- R5: A channel with `ch_en[c]`=0 never raises `out_stb[c]`.
- R6: The base row latency is the sum, over the set bits of `vstage_en` (bit0..bit3), of the weights 2, 1, 3 and 15. Channel 0 (8-bit single plane) has a skip count equal to the base.
- R7: Channels 1 and 3 (luma) have a skip count of base+2 when `ee_en[c]`=1, and base otherwise. Channels 2 and 4 (4:2:0 chroma) have a skip count of base+1.
- R8: With `frame_mode`=1 and at least one channel enabled, pulses fetch lines while the pulse count before the pulse is below P. P is the minimum skip count over the enabled channels. Later pulses fetch nothing, and no fetch occurs between pulses before priming.
- R9: With `frame_mode`=1, once the pulse count reaches P, `load_stb` rises on the next cycle. It then rises every FREE_GAP cycles (default 4) until `frame_height` lines are fetched. Disabled channels play no part in P.
- R10: `min_hblank` is the sum (with `frame_mode`=0) or the maximum (with `frame_mode`=1) over the set bits of `hstage_en` (bit0..bit5) of the weights 50, 62, 25, 25, 26 and 44. It is registered one cycle after its inputs.
- R11: `blank_viol` is high exactly when `hblank_cfg` is below the minimum blanking. It is registered with the same one-cycle latency as R10.
- R12: With `frame_mode`=1 and no channel enabled, the block never primes. Fetches follow pulses as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| frame_start | input | 1 | Restarts all frame counters |
| line_start | input | 1 | Periodic line-start pulse |
| frame_mode | input | 1 | 0 pulse-locked fetch, 1 free-running fetch after priming |
| vstage_en | input | 4 | Enables of the row-delay stages (weights 2,1,3,15) |
| hstage_en | input | 6 | Enables of the cycle-latency stages (weights 50,62,25,25,26,44) |
| ch_en | input | NUM_CH | Output channel enables |
| ee_en | input | NUM_CH | Edge enhancement per channel, used by luma channels |
| frame_height | input | CNT_W | Lines to fetch per frame |
| hblank_cfg | input | BLK_W | Configured horizontal blanking in cycles |
| load_stb | output | 1 | Input-line fetch strobe |
| out_stb | output | NUM_CH | Per-channel output-line strobe |
| min_hblank | output | BLK_W | Required minimum horizontal blanking |
| blank_viol | output | 1 | Configured blanking below minimum |

## Verification
The hardest moment to reach is the hand-over in free-running mode. Here the last pulse-driven fetch and the first timer-driven fetch land on two back-to-back cycles, and only a channel mix that gives P its value decides when that happens. The stimulus enables only the two chroma channels, so P is the chroma skip rather than the smaller skip of the disabled single-plane channel. It then walks each cycle after the third pulse, checking the exact fetch cycles and that fetching stops at the frame height. A separate long run with every row-delay stage enabled checks the skip boundary at pulses 21 and 22.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

    localparam int N_VSTG = 4;
    localparam int N_HSTG = 6;
    localparam int EE_EXTRA_ROWS = 2;
    localparam int CHROMA_EXTRA_ROWS = 1;

    typedef enum logic [1:0] {
        KIND_PLANE8 = 2'd0,
        KIND_LUMA   = 2'd1,
        KIND_CHROMA = 2'd2
    } ch_kind_e;

    // row delay added by each vertical stage
    function automatic int vrow_delay(input int idx);
        case (idx)
            0:       return 2;
            1:       return 1;
            2:       return 3;
            default: return 15;
        endcase
    endfunction

    // cycle latency of each horizontal stage
    function automatic int hcyc_delay(input int idx);
        case (idx)
            0:       return 50;
            1:       return 62;
            2:       return 25;
            3:       return 25;
            4:       return 26;
            default: return 44;
        endcase
    endfunction

endpackage

// File: rtl/lsq_skip_calc.sv
module lsq_skip_calc
    import lsq_pkg::*;
#(
    parameter int NUM_CH = 5,
    parameter int SKIP_W = 16,
    parameter logic [2*NUM_CH-1:0] CH_KIND = 10'b10_01_10_01_00
) (
    input  logic [N_VSTG-1:0] vstage_en,
    input  logic [NUM_CH-1:0] ch_en,
    input  logic [NUM_CH-1:0] ee_en,
    output logic [SKIP_W-1:0] skip_o [NUM_CH],
    output logic [SKIP_W-1:0] min_skip_o,
    output logic              any_en_o
);

    logic [SKIP_W-1:0] base_rows;
    logic [NUM_CH-1:0] luma_mask;
    logic [NUM_CH-1:0] ee_eff;

    always_comb begin
        base_rows = '0;
        for (int i = 0; i < N_VSTG; i++) begin
            if (vstage_en[i]) begin
                base_rows = base_rows + SKIP_W'(vrow_delay(i));
            end
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam logic [1:0] KIND = CH_KIND[2*c +: 2];
        assign luma_mask[c] = (KIND == KIND_LUMA);
        if (KIND == KIND_CHROMA) begin : g_chroma
            assign skip_o[c] = base_rows + SKIP_W'(CHROMA_EXTRA_ROWS);
        end else begin : g_other
            assign skip_o[c] = base_rows + (ee_eff[c] ? SKIP_W'(EE_EXTRA_ROWS) : '0);
        end
    end

    assign ee_eff = ee_en & luma_mask;

    always_comb begin
        min_skip_o = '1;
        any_en_o   = 1'b0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_en[c]) begin
                any_en_o = 1'b1;
                if (skip_o[c] < min_skip_o) begin
                    min_skip_o = skip_o[c];
                end
            end
        end
    end

endmodule

// File: rtl/lsq_blank_calc.sv
module lsq_blank_calc
    import lsq_pkg::*;
#(
    parameter int BLK_W = 16
) (
    input  logic [N_HSTG-1:0] hstage_en,
    input  logic              frame_mode,
    output logic [BLK_W-1:0]  min_blank_o
);

    logic [BLK_W-1:0] sum_c;
    logic [BLK_W-1:0] max_c;

    always_comb begin
        sum_c = '0;
        max_c = '0;
        for (int i = 0; i < N_HSTG; i++) begin
            if (hstage_en[i]) begin
                sum_c = sum_c + BLK_W'(hcyc_delay(i));
                if (BLK_W'(hcyc_delay(i)) > max_c) begin
                    max_c = BLK_W'(hcyc_delay(i));
                end
            end
        end
        min_blank_o = frame_mode ? max_c : sum_c;
    end

endmodule

// File: rtl/lsq_top.sv
module lsq_top
    import lsq_pkg::*;
#(
    parameter int NUM_CH   = 5,
    parameter int CNT_W    = 16,
    parameter int BLK_W    = 16,
    parameter int FREE_GAP = 4,
    parameter logic [2*NUM_CH-1:0] CH_KIND = 10'b10_01_10_01_00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              line_start,
    input  logic              frame_mode,
    input  logic [N_VSTG-1:0] vstage_en,
    input  logic [N_HSTG-1:0] hstage_en,
    input  logic [NUM_CH-1:0] ch_en,
    input  logic [NUM_CH-1:0] ee_en,
    input  logic [CNT_W-1:0]  frame_height,
    input  logic [BLK_W-1:0]  hblank_cfg,
    output logic              load_stb,
    output logic [NUM_CH-1:0] out_stb,
    output logic [BLK_W-1:0]  min_hblank,
    output logic              blank_viol
);

    localparam int GAP_W = (FREE_GAP > 1) ? $clog2(FREE_GAP + 1) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0]  pulses;
        logic [CNT_W-1:0]  loaded;
        logic [GAP_W-1:0]  gap;
        logic              load;
        logic [NUM_CH-1:0] outs;
        logic [BLK_W-1:0]  minblk;
        logic              viol;
    } seq_state_t;

    seq_state_t state_d, state_q;

    logic [CNT_W-1:0] skip_c [NUM_CH];
    logic [CNT_W-1:0] min_skip_c;
    logic             any_en_c;
    logic [BLK_W-1:0] min_blank_c;

    logic [CNT_W-1:0] pulse_num_c;
    logic             room_c;
    logic             primed_c;
    logic             free_run_c;

    lsq_skip_calc #(
        .NUM_CH  (NUM_CH),
        .SKIP_W  (CNT_W),
        .CH_KIND (CH_KIND)
    ) u_skip (
        .vstage_en  (vstage_en),
        .ch_en      (ch_en),
        .ee_en      (ee_en),
        .skip_o     (skip_c),
        .min_skip_o (min_skip_c),
        .any_en_o   (any_en_c)
    );

    lsq_blank_calc #(
        .BLK_W (BLK_W)
    ) u_blank (
        .hstage_en   (hstage_en),
        .frame_mode  (frame_mode),
        .min_blank_o (min_blank_c)
    );

    always_comb begin
        state_d      = state_q;
        state_d.load = 1'b0;
        state_d.outs = '0;

        pulse_num_c = (state_q.pulses == CNT_MAX) ? state_q.pulses
                                                  : state_q.pulses + CNT_W'(1);
        room_c      = (state_q.loaded < frame_height);
        primed_c    = any_en_c && (state_q.pulses >= min_skip_c);
        free_run_c  = frame_mode && primed_c;

        if (frame_start) begin
            state_d.pulses = '0;
            state_d.loaded = '0;
            state_d.gap    = '0;
        end else begin
            if (line_start) begin
                state_d.pulses = pulse_num_c;
                for (int c = 0; c < NUM_CH; c++) begin
                    state_d.outs[c] = ch_en[c] && (pulse_num_c > skip_c[c]);
                end
                if (!free_run_c && room_c) begin
                    state_d.load = 1'b1;
                end
            end
            if (free_run_c && room_c) begin
                if (state_q.gap == '0) begin
                    state_d.load = 1'b1;
                    state_d.gap  = GAP_W'(FREE_GAP - 1);
                end else begin
                    state_d.gap  = state_q.gap - GAP_W'(1);
                end
            end
            if (state_d.load) begin
                state_d.loaded = state_q.loaded + CNT_W'(1);
            end
        end

        state_d.minblk = min_blank_c;
        state_d.viol   = (hblank_cfg < min_blank_c);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign load_stb   = state_q.load;
    assign out_stb    = state_q.outs;
    assign min_hblank = state_q.minblk;
    assign blank_viol = state_q.viol;

endmodule

// File: rtl/lsq_chk.sv
module lsq_chk #(
    parameter int NUM_CH = 5,
    parameter int BLK_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic              line_start,
    input logic              frame_mode,
    input logic [NUM_CH-1:0] ch_en,
    input logic [BLK_W-1:0]  hblank_cfg,
    input logic              load_stb,
    input logic [NUM_CH-1:0] out_stb,
    input logic [BLK_W-1:0]  min_hblank,
    input logic              blank_viol
);

    AST_FS_QUIETS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(frame_start) |-> (!load_stb && out_stb == '0)) else $error("AST_FS_QUIETS"); // R1

    AST_OUT_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_stb != '0) |-> $past(line_start)) else $error("AST_OUT_AFTER_PULSE"); // R2

    AST_LINE_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && !$past(frame_mode)) |-> $past(line_start)) else $error("AST_LINE_LOAD_PULSE"); // R3

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (out_stb & ~$past(ch_en)) == '0) else $error("AST_DISABLED_QUIET"); // R5

    AST_MINBLANK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        min_hblank <= BLK_W'(232)) else $error("AST_MINBLANK_BOUND"); // R10

    AST_VIOL_CONSISTENT: assert property (@(posedge clk) disable iff (!rst_n)
        blank_viol == ($past(hblank_cfg) < min_hblank)) else $error("AST_VIOL_CONSISTENT"); // R11

endmodule

bind lsq_top lsq_chk #(.NUM_CH(NUM_CH), .BLK_W(BLK_W)) u_chk (.*);

// File: tb/sim_lsq_top.sv
module sim_lsq_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        line_start = 1'b0;
    logic        frame_mode = 1'b0;
    logic [3:0]  vstage_en = '0;
    logic [5:0]  hstage_en = '0;
    logic [4:0]  ch_en = '0;
    logic [4:0]  ee_en = '0;
    logic [15:0] frame_height = '0;
    logic [15:0] hblank_cfg = '0;
    logic        load_stb;
    logic [4:0]  out_stb;
    logic [15:0] min_hblank;
    logic        blank_viol;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lsq_top u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
        .frame_mode(frame_mode), .vstage_en(vstage_en), .hstage_en(hstage_en),
        .ch_en(ch_en), .ee_en(ee_en), .frame_height(frame_height), .hblank_cfg(hblank_cfg),
        .load_stb(load_stb), .out_stb(out_stb), .min_hblank(min_hblank), .blank_viol(blank_viol)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_skip(input int c);
        int base;
        base = (vstage_en[0] ? 2 : 0) + (vstage_en[1] ? 1 : 0)
             + (vstage_en[2] ? 3 : 0) + (vstage_en[3] ? 15 : 0);
        if (c == 1 || c == 3) return base + (ee_en[c] ? 2 : 0);
        if (c == 2 || c == 4) return base + 1;
        return base;
    endfunction

    function automatic int exp_outs(input int k);
        int v;
        v = 0;
        for (int c = 0; c < 5; c++) begin
            if (ch_en[c] && k > exp_skip(c)) v = v | (1 << c);
        end
        return v;
    endfunction

    task automatic restart();
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
        chk("R1 load after frame_start", int'(load_stb), 0);
        chk("R1 out after frame_start", int'(out_stb), 0);
    endtask

    task automatic pulse(output int ld, output int outs);
        @(negedge clk) line_start = 1'b1;
        @(negedge clk) line_start = 1'b0;
        ld = int'(load_stb);
        outs = int'(out_stb);
    endtask

    task automatic idle(input int n, output int loads);
        loads = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (load_stb) loads++;
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset load", int'(load_stb), 0);
        chk("R1 reset out", int'(out_stb), 0);
        chk("R10 reset min_hblank", int'(min_hblank), 0);
        chk("R11 reset viol", int'(blank_viol), 0);
    endtask

    task automatic t_line_mode();
        int ld, o, n;
        frame_mode = 1'b0; vstage_en = 4'b0001; ee_en = 5'b00010;
        ch_en = 5'b11111; frame_height = 16'd5;
        restart();
        for (int k = 1; k <= 7; k++) begin
            pulse(ld, o);
            chk($sformatf("R3 line load k=%0d", k), ld, (k <= 5) ? 1 : 0);
            chk($sformatf("R4 R6 R7 outs k=%0d", k), o, exp_outs(k));
            @(negedge clk);
            chk("R2 strobe width load", int'(load_stb), 0);
            chk("R2 strobe width out", int'(out_stb), 0);
            idle(1, n);
        end
        restart();
        pulse(ld, o);
        chk("R1 restart skip outs", o, 0);
        chk("R1 restart load", ld, 1);
    endtask

    task automatic t_disabled();
        int ld, o, n;
        frame_mode = 1'b0; vstage_en = 4'b0110; ee_en = 5'b00000;
        ch_en = 5'b11110; frame_height = 16'd20;
        restart();
        for (int k = 1; k <= 7; k++) begin
            pulse(ld, o);
            chk($sformatf("R5 ch0 disabled k=%0d", k), o & 1, 0);
            chk($sformatf("R4 R7 outs k=%0d", k), o, exp_outs(k));
            idle(2, n);
        end
    endtask

    task automatic t_frame_mode();
        int ld, o, n;
        frame_mode = 1'b1; vstage_en = 4'b0001; ee_en = 5'b00000;
        ch_en = 5'b10100; frame_height = 16'd6;
        restart();
        for (int k = 1; k <= 3; k++) begin
            pulse(ld, o);
            chk($sformatf("R8 priming load k=%0d", k), ld, 1);
            if (k < 3) begin
                idle(2, n);
                chk("R8 no load between pulses", n, 0);
            end
        end
        @(negedge clk);
        chk("R9 first free load", int'(load_stb), 1);
        idle(3, n);
        chk("R9 free gap quiet", n, 0);
        @(negedge clk);
        chk("R9 second free load", int'(load_stb), 1);
        idle(4, n);
        chk("R9 third free load", n, 1);
        idle(8, n);
        chk("R9 stop at frame height", n, 0);
        pulse(ld, o);
        chk("R8 primed pulse no load", ld, 0);
        chk("R4 chroma outs after priming", o, 5'b10100);
    endtask

    task automatic t_no_channel();
        int ld, o, n, total;
        frame_mode = 1'b1; vstage_en = 4'b0001; ch_en = 5'b00000; frame_height = 16'd3;
        restart();
        total = 0;
        for (int k = 1; k <= 5; k++) begin
            pulse(ld, o);
            total += ld;
            chk($sformatf("R12 pulse load k=%0d", k), ld, (k <= 3) ? 1 : 0);
            chk("R5 no outs", o, 0);
            idle(3, n);
            total += n;
        end
        chk("R12 total loads", total, 3);
    endtask

    task automatic t_deep_skip();
        int ld, o, n;
        frame_mode = 1'b0; vstage_en = 4'b1111; ee_en = 5'b00000;
        ch_en = 5'b00001; frame_height = 16'd100;
        restart();
        for (int k = 1; k <= 22; k++) begin
            pulse(ld, o);
            if (k == 21) chk("R6 ch0 quiet at pulse 21", o, 0);
            if (k == 22) chk("R6 ch0 emits at pulse 22", o, 1);
            idle(1, n);
        end
    endtask

    task automatic t_blank();
        @(negedge clk) hstage_en = 6'b000011; frame_mode = 1'b0; hblank_cfg = 16'd100;
        repeat (2) @(negedge clk);
        chk("R10 line sum", int'(min_hblank), 112);
        chk("R11 viol line", int'(blank_viol), 1);
        frame_mode = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 frame max", int'(min_hblank), 62);
        chk("R11 no viol frame", int'(blank_viol), 0);
        hstage_en = 6'b111111; frame_mode = 1'b0; hblank_cfg = 16'd232;
        repeat (2) @(negedge clk);
        chk("R10 all sum", int'(min_hblank), 232);
        chk("R11 equal no viol", int'(blank_viol), 0);
        hstage_en = 6'b110100; frame_mode = 1'b1; hblank_cfg = 16'd43;
        repeat (2) @(negedge clk);
        chk("R10 subset max", int'(min_hblank), 44);
        chk("R11 one below viol", int'(blank_viol), 1);
        frame_mode = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 subset sum", int'(min_hblank), 95);
    endtask

    initial begin
        t_reset();
        t_line_mode();
        t_disabled();
        t_frame_mode();
        t_no_channel();
        t_deep_skip();
        t_blank();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule